// File: doc/BRIEF.md
# Serial Stereo Audio Transmitter

This block takes 16-bit PCM samples written into a 128-entry transmit queue and shifts them out MSB first on a serial data line. A word-select line frames the data. Samples leave the queue strictly in write order and go alternately to the left and the right channel, so software writes interleaved stereo pairs with the left sample first. Word select low means left and high means right. Two framings are selectable: the standard one, where the MSB follows the word-select change by one bit period, and left-justified, where the MSB shares its bit period with the change.

As bus master, the block builds its bit clock from a single-cycle enable pulse (`bclk_tick`) supplied by an external clock divider. It drives that bit clock and a word select it generates itself, toggling every 16 bit periods. As slave, it follows an external bit clock and word select, brought into the system clock domain through two-stage synchronisers. The master and slave roles each have their own polarity bit. That bit chooses which bit-clock edge launches data and word select.

A refill request is raised while queue occupancy is at or below a programmable level. It is held in a sticky pending flag with a mask and a clear. A separate sticky flag records an empty queue at a word boundary, in which case a zero word is sent.

The sequencer has four states. `ST_IDLE` is the disabled state. `ST_ARM` waits for the first launch edge so it can learn the current word-select level. `ST_SYNC` waits for the first left-channel word boundary. `ST_RUN` streams data. The transitions are: IDLE to ARM on enable; ARM to SYNC on the first launch edge; SYNC to RUN when a left word is loaded; any state to IDLE when the enable drops.

Top module: `i2s_tx`

## Requirements
- R1: While `en` is low the block is in `ST_IDLE`. It holds `sdo`, `sck_o` and `ws_o` at 0 and takes nothing from the queue. Queue writes are still accepted.
- R2: In master mode (`mst_mode`=1) every `bclk_tick` pulse toggles `sck_o`, starting from 0. `ws_o` changes every 16 bit periods. In slave mode `sck_o` and `ws_o` stay 0.
- R3: In master mode, `pol_mst`=0 makes `sdo` and `ws_o` change only on the falling edge of `sck_o`. `pol_mst`=1 makes them change only on the rising edge.
- R4: In slave mode the launch edge of `sck_in` is falling when `pol_slv`=0 and rising when `pol_slv`=1. `ws_in` is taken on that same edge.
- R5: Standard framing (`fmt_lj`=0): the MSB of a word goes out in the bit period after a word-select change. The remaining bits follow MSB to LSB, and the LSB falls in the first bit period of the next channel.
- R6: Left-justified framing (`fmt_lj`=1): the MSB goes out in the same bit period as the word-select change, and the next 15 periods carry bits 14 down to 0.
- R7: Word select 0 is the left channel and 1 is the right. After enable the first launch edge is only observed, and `sdo` stays 0 until the first left-channel word is loaded. From then on, each word boundary takes the next queued sample.
- R8: The queue holds 128 samples. `wr_full` is 1 exactly when it holds 128, and a write while full is dropped.
- R9: `trig_pend` becomes 1 on the cycle after occupancy is at or below `trig_level`. It stays 1 until a `trig_clr` pulse on a cycle when occupancy is above the level. `irq` is `trig_pend` gated by `trig_mask`.
- R10: If the queue is empty at a word boundary in `ST_RUN`, a zero word is sent and `underflow` is set. It stays set until `udf_clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Transmitter enable |
| mst_mode | input | 1 | 1 = bus master, 0 = slave |
| fmt_lj | input | 1 | 1 = left-justified, 0 = standard framing |
| pol_mst | input | 1 | Master launch edge: 0 falling, 1 rising |
| pol_slv | input | 1 | Slave launch edge: 0 falling, 1 rising |
| bclk_tick | input | 1 | Half-bit-period enable pulse from the clock divider |
| sck_in | input | 1 | External bit clock (slave) |
| ws_in | input | 1 | External word select (slave) |
| wr_en | input | 1 | Queue write strobe |
| wr_data | input | 16 | Sample to queue |
| wr_full | output | 1 | Queue holds 128 samples |
| trig_level | input | 8 | Refill threshold |
| trig_mask | input | 1 | Interrupt mask, 1 = enabled |
| trig_clr | input | 1 | Clear pending refill flag |
| udf_clr | input | 1 | Clear underflow flag |
| sck_o | output | 1 | Generated bit clock (master) |
| ws_o | output | 1 | Generated word select (master) |
| sdo | output | 1 | Serial data |
| irq | output | 1 | Masked refill request |
| trig_pend | output | 1 | Sticky refill-pending flag |
| underflow | output | 1 | Sticky underflow flag |

## Verification
The bench starts the slave streams in the middle of a right-channel word, so a design that starts on any word boundary rather than a left one would shift the whole stereo stream by one sample. Every combination of role, polarity and framing is sampled on the capture edge. A design that launched on the wrong edge would present the previous bit, and one with the wrong framing offset would be off by one bit period. The bench toggles the external clock while the block is disabled and then checks that the next stream resumes with the next queued sample; a design that popped while idle would skip samples. Draining the queue in master mode checks zero words, the sticky underflow flag, and a refill flag that comes back at once when cleared while occupancy is still low.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_SYNC = 2'd2,
        ST_RUN  = 2'd3
    } tx_state_e;
endpackage

// File: rtl/i2s_tx_fifo.sv
module i2s_tx_fifo #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 128
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [WIDTH-1:0]               wr_data,
    input  logic                           rd_en,
    output logic [WIDTH-1:0]               rd_data,
    output logic                           full,
    output logic                           empty,
    output logic [$clog2(DEPTH+1)-1:0]     level
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic [CW-1:0]    cnt;
    logic             do_wr, do_rd;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign level   = cnt;
    assign rd_data = mem[rp];
    assign do_wr   = wr_en && !full;
    assign do_rd   = rd_en && !empty;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_wr) mem[wp] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_wr) wp <= bump(wp);
            if (do_rd) rp <= bump(rp);
            cnt <= cnt + CW'(do_wr) - CW'(do_rd);
        end
    end

    // R8
    drop_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full && !rd_en) |=> (cnt == $past(cnt)));
    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));
endmodule

// File: rtl/i2s_tx_bitclk.sv
module i2s_tx_bitclk #(
    parameter int CH_BITS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic mst_mode,
    input  logic pol_mst,
    input  logic pol_slv,
    input  logic bclk_tick,
    input  logic sck_in,
    input  logic ws_in,
    output logic launch,
    output logic ws_cur,
    output logic sck_o,
    output logic ws_o
);
    localparam int CNT_W = (CH_BITS > 1) ? $clog2(CH_BITS) : 1;

    logic             sck_q1, sck_q2, sck_q3, ws_q1, ws_q2;
    logic             bclk, mws;
    logic [CNT_W-1:0] cnt;
    logic             launch_m, launch_s, rise_s, fall_s, wrap;

    // two-stage synchronisers for the slave-side inputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {sck_q1, sck_q2, sck_q3} <= '0;
            {ws_q1, ws_q2}           <= '0;
        end else begin
            sck_q1 <= sck_in;
            sck_q2 <= sck_q1;
            sck_q3 <= sck_q2;
            ws_q1  <= ws_in;
            ws_q2  <= ws_q1;
        end
    end

    assign rise_s   = sck_q2 && !sck_q3;
    assign fall_s   = !sck_q2 && sck_q3;
    assign launch_s = en && !mst_mode && (pol_slv ? rise_s : fall_s);
    // master: bclk low->high is rising
    assign launch_m = en && mst_mode && bclk_tick && (pol_mst ? !bclk : bclk);
    assign wrap     = (cnt == CNT_W'(CH_BITS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bclk <= 1'b0;
            mws  <= 1'b0;
            cnt  <= CNT_W'(CH_BITS - 1);
        end else if (!en || !mst_mode) begin
            bclk <= 1'b0;
            mws  <= 1'b0;
            cnt  <= CNT_W'(CH_BITS - 1);
        end else if (bclk_tick) begin
            bclk <= !bclk;
            if (launch_m) begin
                cnt <= wrap ? '0 : cnt + 1'b1;
                if (wrap) mws <= !mws;
            end
        end
    end

    assign launch = launch_m || launch_s;
    assign ws_cur = mst_mode ? (wrap ? !mws : mws) : ws_q2;
    assign sck_o  = bclk;
    assign ws_o   = mws;

    // R2
    tick_toggles_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mst_mode && bclk_tick) |=> (sck_o != $past(sck_o)));
endmodule

// File: rtl/i2s_tx.sv
module i2s_tx
    import i2s_tx_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int FIFO_DEPTH = 128
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              en,
    input  logic                              mst_mode,
    input  logic                              fmt_lj,
    input  logic                              pol_mst,
    input  logic                              pol_slv,
    input  logic                              bclk_tick,
    input  logic                              sck_in,
    input  logic                              ws_in,
    input  logic                              wr_en,
    input  logic [DATA_W-1:0]                 wr_data,
    output logic                              wr_full,
    input  logic [$clog2(FIFO_DEPTH+1)-1:0]   trig_level,
    input  logic                              trig_mask,
    input  logic                              trig_clr,
    input  logic                              udf_clr,
    output logic                              sck_o,
    output logic                              ws_o,
    output logic                              sdo,
    output logic                              irq,
    output logic                              trig_pend,
    output logic                              underflow
);
    localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

    tx_state_e         state, state_nx;
    logic              launch, ws_cur, ws_last, trans, trans_d, load;
    logic [DATA_W-1:0] fifo_rd, word_in, shreg;
    logic              fifo_empty, fifo_pop, do_load, start_ok;
    logic [LVL_W-1:0]  fifo_lvl;
    logic              sdo_r, pend_r, udf_r, refill_cond;

    i2s_tx_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(fifo_pop), .rd_data(fifo_rd),
        .full(wr_full), .empty(fifo_empty), .level(fifo_lvl)
    );

    i2s_tx_bitclk #(.CH_BITS(DATA_W)) u_bitclk (
        .clk(clk), .rst_n(rst_n), .en(en), .mst_mode(mst_mode),
        .pol_mst(pol_mst), .pol_slv(pol_slv), .bclk_tick(bclk_tick),
        .sck_in(sck_in), .ws_in(ws_in),
        .launch(launch), .ws_cur(ws_cur), .sck_o(sck_o), .ws_o(ws_o)
    );

    assign trans    = (ws_cur != ws_last);
    assign load     = fmt_lj ? trans : trans_d;
    assign start_ok = (state == ST_RUN) || (state == ST_SYNC && !ws_cur);
    assign do_load  = en && launch && load && start_ok;
    assign fifo_pop = do_load && !fifo_empty;
    assign word_in  = fifo_empty ? '0 : fifo_rd;

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (en) state_nx = ST_ARM;
            ST_ARM:  if (launch) state_nx = ST_SYNC;
            ST_SYNC: if (do_load) state_nx = ST_RUN;
            ST_RUN:  state_nx = ST_RUN;
        endcase
        if (!en) state_nx = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // serialiser and framing
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sdo_r   <= 1'b0;
            shreg   <= '0;
            ws_last <= 1'b0;
            trans_d <= 1'b0;
        end else if (!en) begin
            sdo_r   <= 1'b0;
            shreg   <= '0;
            trans_d <= 1'b0;
        end else if (launch) begin
            ws_last <= ws_cur;
            unique case (state)
                ST_IDLE, ST_ARM: begin
                    trans_d <= 1'b0;
                    sdo_r   <= 1'b0;
                end
                ST_SYNC, ST_RUN: begin
                    trans_d <= trans;
                    if (do_load) begin
                        sdo_r <= word_in[DATA_W-1];
                        shreg <= word_in << 1;
                    end else begin
                        sdo_r <= (state == ST_RUN) ? shreg[DATA_W-1] : 1'b0;
                        shreg <= shreg << 1;
                    end
                end
            endcase
        end
    end

    // refill request and underflow flags
    assign refill_cond = (fifo_lvl <= trig_level);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_r <= 1'b0;
            udf_r  <= 1'b0;
        end else begin
            if (refill_cond)   pend_r <= 1'b1;
            else if (trig_clr) pend_r <= 1'b0;
            if (do_load && fifo_empty && state == ST_RUN) udf_r <= 1'b1;
            else if (udf_clr)                             udf_r <= 1'b0;
        end
    end

    assign sdo       = sdo_r;
    assign trig_pend = pend_r;
    assign irq       = pend_r && trig_mask;
    assign underflow = udf_r;

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !sdo);
    // R3
    ws_on_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mst_mode && !launch) |=> $stable(ws_o));
    // R9
    clr_drops_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_clr && !refill_cond) |=> !trig_pend);
    // R9
    pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_pend && !trig_clr) |=> trig_pend);
    // R10
    udf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow && !udf_clr) |=> underflow);
endmodule

// File: tb/tb_i2s_tx.sv
module tb_i2s_tx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0, mst_mode = 1'b0, fmt_lj = 1'b0;
    logic        pol_mst = 1'b0, pol_slv = 1'b0, bclk_tick = 1'b0;
    logic        sck_in = 1'b1, ws_in = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [7:0]  trig_level = 8'd96;
    logic        trig_mask = 1'b0, trig_clr = 1'b0, udf_clr = 1'b0;
    logic        wr_full, sck_o, ws_o, sdo, irq, trig_pend, underflow;

    int checks = 0, errors = 0;

    // reference model state
    logic [15:0] mq[$];
    bit          bits[$];
    int          phase;
    bit          wprev, tdp, m_udf;

    always #2 clk = !clk;

    i2s_tx dut (
        .clk(clk), .rst_n(rst_n), .en(en), .mst_mode(mst_mode), .fmt_lj(fmt_lj),
        .pol_mst(pol_mst), .pol_slv(pol_slv), .bclk_tick(bclk_tick),
        .sck_in(sck_in), .ws_in(ws_in), .wr_en(wr_en), .wr_data(wr_data),
        .wr_full(wr_full), .trig_level(trig_level), .trig_mask(trig_mask),
        .trig_clr(trig_clr), .udf_clr(udf_clr), .sck_o(sck_o), .ws_o(ws_o),
        .sdo(sdo), .irq(irq), .trig_pend(trig_pend), .underflow(underflow)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                errors++;
                $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
                summary();
            end
        end
    end

    task automatic push(input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (mq.size() < 128) mq.push_back(d);
    endtask

    task automatic model_reset();
        phase = 0; tdp = 0; wprev = 0;
        bits.delete();
    endtask

    // expected sdo for the bit period whose word select is w (R5, R6, R7, R10)
    function automatic bit model_bit(input bit w, input bit lj);
        bit tr, ld;
        logic [15:0] word;
        if (phase == 0) begin
            wprev = w; tdp = 0; phase = 1;
            return 1'b0;
        end
        tr = (w != wprev);
        ld = lj ? tr : tdp;
        tdp = tr; wprev = w;
        if (ld && (phase == 2 || !w)) begin
            phase = 2;
            if (mq.size() > 0) word = mq.pop_front();
            else begin word = '0; m_udf = 1; end
            bits.delete();
            for (int i = 15; i >= 0; i--) bits.push_back(word[i]);
        end
        if (phase == 2 && bits.size() > 0) return bits.pop_front();
        return 1'b0;
    endfunction

    // slave stream: bench drives sck_in/ws_in, samples sdo on capture edge
    task automatic run_slave(input bit pol, input bit lj, input int nper, input int h, input string req);
        en = 1'b0; mst_mode = 1'b0; pol_slv = pol; fmt_lj = lj;
        sck_in = !pol;
        repeat (6) @(negedge clk);
        model_reset();
        en = 1'b1;
        repeat (3) @(negedge clk);
        for (int p = 0; p < nper; p++) begin
            bit w, e;
            w = ((p + 21) / 16) % 2;
            sck_in = pol; ws_in = w;
            repeat (h) @(negedge clk);
            e = model_bit(w, lj);
            check(sdo === e, req, sdo, e);
            sck_in = !pol;
            repeat (h) @(negedge clk);
        end
        en = 1'b0;
        @(negedge clk);
    endtask

    // master stream: bench pulses bclk_tick, watches sck_o/ws_o
    task automatic run_master(input bit pol, input bit lj, input int nper, input int h, input string req);
        bit prev, seen, wlast, first_run;
        int per = 0, run = 0, cyc = 0;
        en = 1'b0; mst_mode = 1'b1; pol_mst = pol; fmt_lj = lj;
        repeat (3) @(negedge clk);
        model_reset();
        check(sck_o === 1'b0 && ws_o === 1'b0, "R1 idle master outputs", sck_o, 0);
        en = 1'b1;
        prev = 1'b0; seen = 0; first_run = 1; wlast = 0;
        while (per < nper) begin
            @(negedge clk);
            if (sck_o != prev) begin
                bit cap;
                cap = pol ? (prev && !sck_o) : (!prev && sck_o);
                if (!cap) seen = 1;
                else if (seen) begin
                    bit e;
                    e = model_bit(ws_o, lj);
                    check(sdo === e, req, sdo, e);
                    if (per > 0 && ws_o != wlast) begin
                        if (!first_run) check(run == 16, "R2 ws_o run length", run, 16);
                        first_run = 0;
                        run = 0;
                    end
                    run++;
                    wlast = ws_o;
                    per++;
                end
            end
            prev = sck_o;
            bclk_tick = (cyc % h == 0);
            cyc++;
        end
        bclk_tick = 1'b0;
        en = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        m_udf = 0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(sdo === 1'b0, "R1 sdo after reset", sdo, 0);
        check(sck_o === 1'b0, "R1 sck_o after reset", sck_o, 0);
        check(ws_o === 1'b0, "R1 ws_o after reset", ws_o, 0);
        check(wr_full === 1'b0, "R8 not full after reset", wr_full, 0);
        @(negedge clk);
        // R9: empty queue is at or below level, masked off
        check(trig_pend === 1'b1, "R9 pend when empty", trig_pend, 1);
        check(irq === 1'b0, "R9 irq masked", irq, 0);

        // R8: fill past capacity
        for (int i = 0; i < 130; i++) push(16'((i * 16'h1357) ^ 16'h8421));
        check(wr_full === 1'b1, "R8 full at 128", wr_full, 1);
        @(negedge clk); trig_clr = 1'b1;
        @(negedge clk); trig_clr = 1'b0;
        @(negedge clk);
        check(trig_pend === 1'b0, "R9 clear above level", trig_pend, 0);
        trig_mask = 1'b1;

        // slave, falling launch, standard framing
        run_slave(1'b0, 1'b0, 320, 6, "R4 R5 R7 slave pol0 standard");
        check(sdo === 1'b0, "R1 sdo after disable", sdo, 0);
        check(wr_full === 1'b0, "R8 full drops after pops", wr_full, 0);

        // R1: toggling while disabled must not consume samples
        for (int p = 0; p < 40; p++) begin
            sck_in = !sck_in; ws_in = p[3];
            repeat (6) @(negedge clk);
            check(sdo === 1'b0, "R1 disabled sdo", sdo, 0);
        end

        // slave, rising launch, left-justified (stream resumes with next sample: R1)
        run_slave(1'b1, 1'b1, 320, 6, "R4 R6 R7 slave pol1 left-justified");

        // R9: occupancy now at or below 96
        check(mq.size() <= 96, "R9 bench drained", mq.size(), 96);
        check(trig_pend === 1'b1 && irq === 1'b1, "R9 pend and irq set", irq, 1);
        @(negedge clk); trig_clr = 1'b1;
        @(negedge clk); trig_clr = 1'b0;
        @(negedge clk);
        check(trig_pend === 1'b1, "R9 clear while low re-sets", trig_pend, 1);
        check(underflow === 1'b0, "R10 no underflow yet", underflow, 0);

        // master modes
        run_master(1'b0, 1'b0, 400, 3, "R2 R3 R5 master pol0 standard");
        run_master(1'b1, 1'b1, 400, 3, "R2 R3 R6 master pol1 left-justified");
        // drain to underflow
        run_master(1'b0, 1'b1, 1400, 2, "R10 master drain");
        check(mq.size() == 0 && m_udf, "R10 model drained", mq.size(), 0);
        check(underflow === 1'b1, "R10 underflow set", underflow, 1);
        @(negedge clk); udf_clr = 1'b1;
        @(negedge clk); udf_clr = 1'b0;
        @(negedge clk);
        check(underflow === 1'b0, "R10 underflow cleared", underflow, 0);
        summary();
    end
endmodule